// File: doc/BRIEF.md
# Keyed Byte-Write Unlock Guard for a Clock-Control Register

This block holds a 16-bit clock-control register and keeps software from changing it by accident. It watches a plain byte-write bus (address, write data, byte-lane enables, write strobe) and a separate instruction-cycle strobe. Each high pulse of the instruction-cycle strobe marks one instruction. The bus is looked at only in such cycles, and the write strobe tells whether that instruction writes.

Each byte lane of the register has its own guard state machine and its own two-byte key. A lane opens only when its two key bytes arrive as writes to that lane on two back-to-back instructions. It then stays open for exactly the next instruction. A write to the lane during that instruction replaces the byte. From the bus, a bit-set or bit-clear instruction is simply a byte write of the modified value, so it is handled in the same way.

The states of each lane are `LK_IDLE` (locked), `LK_HALF` (first key seen) and `LK_OPEN` (window open). The transitions are:
- `arm`: IDLE→HALF on the first key.
- `unlock`: HALF→OPEN on the second key.
- `abort`: HALF→IDLE on any other instruction.
- `close`: OPEN→IDLE on the next instruction, whether or not it writes.
- `stay`: no change when the instruction strobe is low.

Top module: `clkreg_unlock_guard`

## Requirements
- R1: While reset is low and after it is released, the register reads its reset value (default 0x0A05), and both lanes are locked.
- R2: Byte writes of 0x46 and then 0x57 to the low lane (lane enable bit 0, data bits 7:0), on two consecutive instructions, open the low lane. A low-lane write on the next instruction updates register bits 7:0, visible after the clock edge of that instruction.
- R3: Byte writes of 0x78 and then 0x9A to the high lane (lane enable bit 1, data bits 15:8), on consecutive instructions, open the high lane in the same way, and the next high-lane write updates bits 15:8.
- R4: A write to a lane that is not open is discarded, and the register keeps its value.
- R5: The window covers exactly one instruction. It closes after that instruction even if the instruction wrote nothing, so a later write is discarded.
- R6: Between the two key bytes, any of the following returns the lane to locked, and the sequence must start again: an instruction that does not write, a write to another address, a write that does not enable this lane, or a wrong byte value.
- R7: Cycles with the instruction strobe low do not advance, abort or close any lane, and a write strobe in such a cycle is ignored.
- R8: The two lanes are independent. Unlocking one lane does not open the other. Both lanes may be unlocked and written together, using writes that enable both lanes.
- R9: Key writes themselves never change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_stb | input | 1 | High for one cycle per instruction |
| bus_we | input | 1 | The current instruction writes |
| bus_addr | input | ADDR_W | Write address |
| bus_be | input | REG_W/8 | Byte-lane enables, bit 0 for bits 7:0 |
| bus_wdata | input | REG_W | Write data |
| ctl_q | output | REG_W | Protected register value |

## Verification
Every register update, and every lane state change, takes effect at the one clock edge where the instruction strobe is high. The protected value is therefore due one edge after the instruction that writes it. The bench drives each instruction on a falling edge and advances a behavioural model of the lanes by the same instruction. It compares the register with the model on the next falling edge, and on every gap cycle as well. A discarded write therefore shows up as a mismatch within one cycle.

// File: rtl/clkreg_unlock_pkg.sv
package clkreg_unlock_pkg;
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lk_state_e;
endpackage

// File: rtl/clkreg_lane_guard.sv
module clkreg_lane_guard
    import clkreg_unlock_pkg::*;
#(
    parameter logic [7:0] KEY_A   = 8'h46,
    parameter logic [7:0] KEY_B   = 8'h57,
    parameter logic [7:0] RST_VAL = 8'h05
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_stb,
    input  logic       lane_hit,
    input  logic [7:0] lane_byte,
    output logic [7:0] byte_q
);
    lk_state_e state_q, state_d;
    logic      take_write;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm, unlock, abort, close, stay
    always_comb begin
        state_d = state_q;
        if (instr_stb) begin
            unique case (state_q)
                LK_IDLE: state_d = (lane_hit && lane_byte == KEY_A) ? LK_HALF : LK_IDLE;
                LK_HALF: state_d = (lane_hit && lane_byte == KEY_B) ? LK_OPEN : LK_IDLE;
                LK_OPEN: state_d = LK_IDLE;
                default: state_d = LK_IDLE;
            endcase
        end
    end

    // output: protected byte
    always_comb take_write = instr_stb && lane_hit && (state_q == LK_OPEN);

    always_ff @(posedge clk) begin
        if (!rst_n)          byte_q <= RST_VAL;
        else if (take_write) byte_q <= lane_byte;
    end

    // R4, R9: locked lane never changes
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LK_OPEN) |=> $stable(byte_q));

    // R5: window lasts one instruction
    p_window_one_instr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && instr_stb) |=> (state_q == LK_IDLE));

    // R7: no strobe, no movement
    p_no_stb_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_stb |=> $stable(state_q) && $stable(byte_q));

    // R2: open window write lands
    p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && instr_stb && lane_hit) |=> (byte_q == $past(lane_byte)));

    // R6: open only straight from the half state
    p_open_from_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LK_OPEN) |-> ($past(state_q) == LK_HALF));
endmodule

// File: rtl/clkreg_unlock_guard.sv
module clkreg_unlock_guard #(
    parameter int                ADDR_W   = 12,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h1A0,
    parameter logic [REG_W-1:0]  RST_VAL  = 16'h0A05,
    parameter logic [REG_W-1:0]  KEY_1ST  = 16'h7846,
    parameter logic [REG_W-1:0]  KEY_2ND  = 16'h9A57
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_stb,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W/8-1:0]   bus_be,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     ctl_q
);
    localparam int LANES = REG_W / 8;

    logic addr_hit;
    always_comb addr_hit = bus_we && (bus_addr == REG_ADDR);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_hit;
        always_comb lane_hit = addr_hit && bus_be[g];

        clkreg_lane_guard #(
            .KEY_A  (KEY_1ST[g*8 +: 8]),
            .KEY_B  (KEY_2ND[g*8 +: 8]),
            .RST_VAL(RST_VAL[g*8 +: 8])
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .instr_stb(instr_stb),
            .lane_hit (lane_hit),
            .lane_byte(bus_wdata[g*8 +: 8]),
            .byte_q   (ctl_q[g*8 +: 8])
        );
    end

    // R1: reset value one edge after reset
    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == RST_VAL));

    // R4: foreign address writes never touch the register
    p_foreign_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_stb && bus_we && bus_addr != REG_ADDR) |=> $stable(ctl_q));
endmodule

// File: tb/clkreg_unlock_guard_bench.sv
module clkreg_unlock_guard_bench;
    localparam logic [11:0] A = 12'h1A0;
    localparam logic [15:0] RV = 16'h0A05;

    logic clk = 0, rst_n = 0, stb = 0, we = 0;
    logic [11:0] addr = '0;
    logic [1:0]  be = '0;
    logic [15:0] wd = '0, q;
    int errors = 0, checks = 0;
    int ls[2];
    logic [15:0] exp_q;
    int k1[2] = '{8'h46, 8'h78};
    int k2[2] = '{8'h57, 8'h9A};

    always #10 clk = ~clk;

    clkreg_unlock_guard u_clkreg_unlock_guard (
        .clk(clk), .rst_n(rst_n), .instr_stb(stb), .bus_we(we),
        .bus_addr(addr), .bus_be(be), .bus_wdata(wd), .ctl_q(q));

    task automatic chk(string req);
        checks++;
        if (q !== exp_q) begin
            errors++;
            $display("FAIL %s: ctl_q=%h expected %h", req, q, exp_q);
        end
    endtask

    // behavioural model of one instruction
    task automatic model_instr(bit w, logic [11:0] ad, logic [1:0] b, logic [15:0] d);
        for (int l = 0; l < 2; l++) begin
            bit hit = w && ad == A && b[l];
            int by = d[l*8 +: 8];
            if (ls[l] == 0)      ls[l] = (hit && by == k1[l]) ? 1 : 0;
            else if (ls[l] == 1) ls[l] = (hit && by == k2[l]) ? 2 : 0;
            else begin
                if (hit) exp_q[l*8 +: 8] = by[7:0];
                ls[l] = 0;
            end
        end
    endtask

    task automatic instr(bit w, logic [11:0] ad, logic [1:0] b, logic [15:0] d, string req);
        stb = 1; we = w; addr = ad; be = b; wd = d;
        model_instr(w, ad, b, d);
        @(posedge clk); @(negedge clk);
        stb = 0; we = 0;
        chk(req);
    endtask

    // cycles without instruction strobe; bus may carry a write
    task automatic gap(int n, bit w, logic [15:0] d, string req);
        for (int i = 0; i < n; i++) begin
            we = w; addr = A; be = 2'b11; wd = d; stb = 0;
            @(posedge clk); @(negedge clk);
            chk(req);
        end
        we = 0;
    endtask

    task automatic wlo(logic [7:0] v, string req); instr(1, A, 2'b01, {8'h00, v}, req); endtask
    task automatic whi(logic [7:0] v, string req); instr(1, A, 2'b10, {v, 8'h00}, req); endtask

    task automatic do_reset(string req);
        rst_n = 0; ls[0] = 0; ls[1] = 0; exp_q = RV;
        @(posedge clk); @(negedge clk); chk(req);
        @(posedge clk); @(negedge clk); chk(req);
        rst_n = 1;
        @(negedge clk); chk(req);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        wlo(8'h11, "R4 write while locked");
        whi(8'h22, "R4 high write while locked");
        // R2 and R9
        wlo(8'h46, "R9 first key"); wlo(8'h57, "R9 second key");
        wlo(8'hC3, "R2 unlocked low write");
        wlo(8'h33, "R5 second write after window");
        // R5 window closes on non-write instruction
        wlo(8'h46, "R5"); wlo(8'h57, "R5");
        instr(0, A, 2'b00, 16'h0, "R5 idle instruction");
        wlo(8'h44, "R5 write after closed window");
        // R6 interruptions
        wlo(8'h46, "R6"); instr(0, A, 0, 0, "R6 nop between keys");
        wlo(8'h57, "R6"); wlo(8'h55, "R6 after nop");
        wlo(8'h46, "R6"); instr(1, 12'h1A2, 2'b01, 16'h0057, "R6 other address");
        wlo(8'h57, "R6"); wlo(8'h66, "R6 after other address");
        wlo(8'h46, "R6"); wlo(8'h58, "R6 wrong key"); wlo(8'h77, "R6 after wrong key");
        wlo(8'h46, "R6"); instr(1, A, 2'b10, 16'h4657, "R6 other lane only");
        wlo(8'h57, "R6"); wlo(8'h88, "R6 after other lane");
        // R7 strobe-low cycles
        wlo(8'h46, "R7"); gap(3, 1, 16'hFFFF, "R7 gap after first key");
        wlo(8'h57, "R7"); gap(2, 1, 16'hEEEE, "R7 gap in window");
        wlo(8'h99, "R7 write after gaps");
        // R3
        whi(8'h78, "R3"); whi(8'h9A, "R3"); whi(8'h5A, "R3 unlocked high write");
        // R8 independence
        wlo(8'h46, "R8"); wlo(8'h57, "R8"); whi(8'hA5, "R8 low unlock used on high");
        wlo(8'h12, "R8 low window consumed");
        instr(1, A, 2'b11, 16'h7846, "R8"); instr(1, A, 2'b11, 16'h9A57, "R8");
        instr(1, A, 2'b11, 16'hBEEF, "R8 both lanes written");
        // R1 reset mid-unlock
        wlo(8'h46, "R1"); wlo(8'h57, "R1");
        do_reset("R1 reset during window");
        wlo(8'h21, "R1 write after reset locked");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule